// File: doc/BRIEF.md
# Byte-Collecting Receive FIFO with Packed Word Read

This block sits between a serial receive engine and a register read port. The engine hands over one byte per accepted push, and the FIFO holds up to `DEPTH` bytes. Software reads 32-bit words from a data port. Each read removes up to four bytes from the head. The oldest byte lands in the least significant lane. When fewer than four bytes are held, one read drains what is there. Those bytes are packed from the low end and the unused lanes read as zero.

A 12-bit status word reports how much data the FIFO holds:
- Bits 10:4 hold the byte count.
- Bit 11 shows that the FIFO is empty.
- Bits 1, 2 and 3 are fill-threshold flags.
- Bit 0 is a data-ready flag that also drives the ready interrupt line.

A read of an empty FIFO returns zero and raises a sticky underrun flag. That flag stays up until an acknowledge clears it. A flush strobe discards everything held. When the FIFO is full, the engine is stalled through a ready handshake and no byte is lost.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the status word reads 0x800 (only the empty bit set), `push_ready_o` is 1 and `int_underrun_o` is 0.
- R2: With four or more bytes held, a read returns the four oldest bytes: oldest in bits 7:0, the next in 15:8, then 23:16, then 31:24. It removes exactly those four bytes.
- R3: Status bits 10:4 always equal the number of bytes held, and bit 11 is 1 exactly when that number is zero.
- R4: Status bits 1, 2 and 3 are 1 exactly when at least 16, 32 and 64 bytes are held, respectively.
- R5: Status bit 0 is 1 when at least four bytes are held, or when at least one byte is held while `xfer_active_i` is 0. `int_ready_o` always equals status bit 0.
- R6: With 1 to 3 bytes held, a read returns them packed from bits 7:0 upward with zeros in the unused upper bytes and removes them, whether or not `xfer_active_i` is high.
- R7: A read of an empty FIFO returns 0 and leaves the count at zero. It sets `int_underrun_o` from the next cycle on, and the flag stays set until `underrun_ack_i` is pulsed.
- R8: `push_ready_o` is 0 exactly when `DEPTH` bytes are held. A push offered while it is 0 is not stored and the count does not change.
- R9: A `flush_i` pulse empties the FIFO by the next cycle. A push or read in the same cycle has no effect on the contents.
- R10: When a push and a read fall in the same cycle, the new count is the old count plus one minus the bytes the read removed, and the pushed byte follows the older bytes in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all held bytes |
| xfer_active_i | input | 1 | High while the serial transfer is still running |
| push_valid_i | input | 1 | Engine offers a byte |
| push_byte_i | input | 8 | Offered byte |
| push_ready_o | output | 1 | FIFO can take a byte this cycle |
| rd_en_i | input | 1 | Data-port read strobe |
| rd_data_o | output | 32 | Packed head word, valid in the cycle of the strobe |
| status_o | output | 12 | Ready, threshold, count and empty fields |
| int_ready_o | output | 1 | Data-ready interrupt line |
| int_underrun_o | output | 1 | Sticky empty-read flag |
| underrun_ack_i | input | 1 | Clears the underrun flag |

## Verification
The bench builds the block with its default depth of 64 bytes. At that depth the highest threshold flag and the full stall fall on the same count. One run of 64 pushes therefore covers all three threshold edges, the stall and the blocked extra push. Short reads are exercised both while the transfer is active and after it has ended, which separates the two branches of the ready rule. A same-cycle push and read starting from five bytes checks both the count and the byte order across the head.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned THR_LO     = 16;
  localparam int unsigned THR_MID    = 32;
  localparam int unsigned THR_HI     = 64;

  // bytes a single data-port read removes
  function automatic logic [2:0] take_of(input logic [6:0] avail);
    return (avail >= 7'(WORD_BYTES)) ? 3'd4 : avail[2:0];
  endfunction

  // zero the lanes at or above n
  function automatic logic [31:0] pack_low(input logic [31:0] head, input logic [2:0] n);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 4; i++)
      if (i < int'(n)) w[8*i +: 8] = head[8*i +: 8];
    return w;
  endfunction

  function automatic logic [11:0] make_status(input logic [6:0] cnt, input logic active);
    logic [11:0] s;
    s[11]   = (cnt == 7'd0);
    s[10:4] = cnt;
    s[3]    = (cnt >= 7'(THR_HI));
    s[2]    = (cnt >= 7'(THR_MID));
    s[1]    = (cnt >= 7'(THR_LO));
    s[0]    = (cnt >= 7'(WORD_BYTES)) || ((cnt != 7'd0) && !active);
    return s;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  input  logic        pop,
  input  logic [2:0]  pop_n,
  output logic [31:0] head_o
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + AW'(1);
      if (pop)   rptr <= rptr + AW'(pop_n);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [AW-1:0] idx;
    assign idx = rptr + AW'(g);
    assign head_o[8*g +: 8] = mem[idx];
  end
endmodule

// File: rtl/rxf_count.sv
module rxf_count #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          inc,
  input  logic [2:0]    dec_n,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || flush) cnt_o <= '0;
    else                 cnt_o <= cnt_o + CW'(inc) - CW'(dec_n);
  end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic        xfer_active_i,
  input  logic        push_valid_i,
  input  logic [7:0]  push_byte_i,
  output logic        push_ready_o,
  input  logic        rd_en_i,
  output logic [31:0] rd_data_o,
  output logic [11:0] status_o,
  output logic        int_ready_o,
  output logic        int_underrun_o,
  input  logic        underrun_ack_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic [6:0]    cnt7;
  logic [2:0]    take_n;
  logic [31:0]   head;
  // named events for the checker
  logic          push_fire, pop_fire, empty_rd;
  logic [2:0]    dec_n;

  assign cnt7         = 7'(cnt);
  assign take_n       = take_of(cnt7);
  assign push_ready_o = (cnt7 < 7'(DEPTH));
  assign push_fire    = push_valid_i && push_ready_o && !flush_i;
  assign pop_fire     = rd_en_i && (cnt7 != 7'd0) && !flush_i;
  assign empty_rd     = rd_en_i && (cnt7 == 7'd0);
  assign dec_n        = pop_fire ? take_n : 3'd0;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .wr_en(push_fire), .wr_byte(push_byte_i),
    .pop(pop_fire), .pop_n(take_n), .head_o(head)
  );

  rxf_count #(.DEPTH(DEPTH)) u_count (
    .clk(clk), .rst_n(rst_n), .flush(flush_i),
    .inc(push_fire), .dec_n(dec_n), .cnt_o(cnt)
  );

  assign rd_data_o   = pack_low(head, (cnt7 == 7'd0) ? 3'd0 : take_n);
  assign status_o    = make_status(cnt7, xfer_active_i);
  assign int_ready_o = status_o[0];

  always_ff @(posedge clk) begin
    if (!rst_n)              int_underrun_o <= 1'b0;
    else if (empty_rd)       int_underrun_o <= 1'b1;
    else if (underrun_ack_i) int_underrun_o <= 1'b0;
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flush_i,
  input logic        push_fire,
  input logic        pop_fire,
  input logic        empty_rd,
  input logic [2:0]  take_n,
  input logic        push_ready_o,
  input logic [11:0] status_o,
  input logic [31:0] rd_data_o,
  input logic        int_underrun_o
);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[10:4] <= 7'(DEPTH));
  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !push_ready_o |-> status_o[10:4] == 7'(DEPTH));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (status_o[11] && status_o[10:4] == 7'd0));
  assert_underrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    empty_rd |=> int_underrun_o);
  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    empty_rd |-> rd_data_o == 32'd0);
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |=> status_o[10:4] == $past(status_o[10:4]) + 7'($past(push_fire))
                 - ($past(pop_fire) ? 7'($past(take_n)) : 7'd0));
endmodule

bind rx_word_fifo rxf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
  .push_fire(push_fire), .pop_fire(pop_fire), .empty_rd(empty_rd),
  .take_n(take_n), .push_ready_o(push_ready_o), .status_o(status_o),
  .rd_data_o(rd_data_o), .int_underrun_o(int_underrun_o)
);

// File: tb/rx_word_fifo_tb.sv
module rx_word_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0, xfer_active_i = 1'b1;
  logic        push_valid_i = 1'b0, rd_en_i = 1'b0, underrun_ack_i = 1'b0;
  logic [7:0]  push_byte_i = '0;
  logic        push_ready_o, int_ready_o, int_underrun_o;
  logic [31:0] rd_data_o;
  logic [11:0] status_o;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rx_word_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .xfer_active_i(xfer_active_i),
    .push_valid_i(push_valid_i), .push_byte_i(push_byte_i), .push_ready_o(push_ready_o),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .status_o(status_o),
    .int_ready_o(int_ready_o), .int_underrun_o(int_underrun_o),
    .underrun_ack_i(underrun_ack_i)
  );

  function automatic logic [11:0] want_stat(input int c, input logic act);
    logic [11:0] s;
    s = '0;
    s[11] = (c == 0);
    s[10:4] = 7'(c);
    s[3] = c > 63;
    s[2] = c > 31;
    s[1] = c > 15;
    s[0] = (c > 3) || (c > 0 && !act);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h want %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    push_valid_i = 1'b1; push_byte_i = b;
    step();
    push_valid_i = 1'b0;
  endtask

  task automatic read(output logic [31:0] d);
    rd_en_i = 1'b1; #1 d = rd_data_o;
    step();
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset();
    check(status_o == 12'h800, "R1 status", 32'(status_o), 32'h800);
    check(push_ready_o && !int_underrun_o, "R1 ready/underrun",
          {30'd0, push_ready_o, int_underrun_o}, 32'h2);
  endtask

  task automatic t_words();
    logic [31:0] d;
    xfer_active_i = 1'b1;
    for (int i = 0; i < 8; i++) push(8'h11 + 8'(i));
    check(status_o == want_stat(8, 1), "R3 count 8", 32'(status_o), 32'(want_stat(8, 1)));
    check(int_ready_o, "R5 ready irq", 32'(int_ready_o), 32'd1);
    read(d); check(d == 32'h14131211, "R2 first word", d, 32'h14131211);
    read(d); check(d == 32'h18171615, "R2 second word", d, 32'h18171615);
    check(status_o == 12'h800, "R3 empty", 32'(status_o), 32'h800);
  endtask

  task automatic t_thresholds();
    for (int i = 1; i <= 64; i++) begin
      push(8'(i));
      if (i == 15 || i == 16 || i == 31 || i == 32 || i == 63 || i == 64)
        check(status_o == want_stat(i, 1), "R4 threshold", 32'(status_o), 32'(want_stat(i, 1)));
    end
    check(!push_ready_o, "R8 stall at full", 32'(push_ready_o), 32'd0);
    push(8'hEE);
    check(status_o[10:4] == 7'd64, "R8 blocked push", 32'(status_o[10:4]), 32'd64);
    flush_i = 1'b1; step(); flush_i = 1'b0;
    check(status_o == 12'h800 && push_ready_o, "R9 flush", 32'(status_o), 32'h800);
  endtask

  task automatic t_short();
    logic [31:0] d;
    xfer_active_i = 1'b1;
    push(8'hA1); push(8'hA2); push(8'hA3);
    check(status_o == want_stat(3, 1), "R5 not ready while active", 32'(status_o), 32'(want_stat(3, 1)));
    xfer_active_i = 1'b0; #1;
    check(status_o[0] && int_ready_o, "R5 ready after end", 32'(status_o), 32'(want_stat(3, 0)));
    read(d); check(d == 32'h00A3A2A1, "R6 three bytes", d, 32'h00A3A2A1);
    check(status_o == 12'h800, "R6 drained", 32'(status_o), 32'h800);
    xfer_active_i = 1'b1;
    push(8'hB1); push(8'hB2);
    read(d); check(d == 32'h0000B2B1, "R6 active partial", d, 32'h0000B2B1);
    check(status_o == 12'h800, "R6 removed", 32'(status_o), 32'h800);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    read(d); check(d == 32'd0, "R7 zero data", d, 32'd0);
    check(int_underrun_o && status_o == 12'h800, "R7 flag set", {31'd0, int_underrun_o}, 32'd1);
    step();
    check(int_underrun_o, "R7 sticky", {31'd0, int_underrun_o}, 32'd1);
    underrun_ack_i = 1'b1; step(); underrun_ack_i = 1'b0;
    check(!int_underrun_o, "R7 ack clears", {31'd0, int_underrun_o}, 32'd0);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) push(8'hC1 + 8'(i));
    push_valid_i = 1'b1; push_byte_i = 8'hC6; rd_en_i = 1'b1;
    #1 d = rd_data_o;
    step();
    push_valid_i = 1'b0; rd_en_i = 1'b0;
    check(d == 32'hC4C3C2C1, "R10 word", d, 32'hC4C3C2C1);
    check(status_o[10:4] == 7'd2, "R10 count", 32'(status_o[10:4]), 32'd2);
    read(d); check(d == 32'h0000C6C5, "R10 order", d, 32'h0000C6C5);
  endtask

  task automatic t_flush_push();
    push(8'hD1); push(8'hD2);
    flush_i = 1'b1; push_valid_i = 1'b1; push_byte_i = 8'hD3;
    step();
    flush_i = 1'b0; push_valid_i = 1'b0;
    check(status_o == 12'h800, "R9 push ignored on flush", 32'(status_o), 32'h800);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_words();
    t_thresholds();
    t_short();
    t_underrun();
    t_simul();
    t_flush_push();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout want completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule